// File: doc/BRIEF.md
# Command-Triggered Transfer FIFO Engine

This block moves data between a host register bus and a memory-card bus through a 512-byte FIFO. A single 32-bit command write starts a transfer. The word gives a command code, a byte length, a direction and a bit that engages the large buffer. The host fills or drains the FIFO through a 32-bit window, with the most significant byte first. The card side moves one byte per handshake.

An engine counts card-side bytes against the commanded length and ends the transfer. When it finishes it clears busy and sets a sticky done flag. It also keeps two sticky error flags. The first records a window read of an empty FIFO. The second records any disagreement between the bytes moved and the commanded length. A soft-reset bit returns the engine and the FIFO to their idle state.

Register offsets (bytes): 0x00 command, 0x04 control (bit 0 = soft reset, write only), 0x08 data window, 0x0C status, 0x10 FIFO level. Status bits: [0] busy, [1] done, [2] empty, [3] full, [4] underrun, [5] mismatch, [6] direction, [25:16] byte count, [31:28] command code. Reads of the command and control offsets return zero.

Top module: `xfer_fifo_engine`

## Requirements
- R1: After reset the status reads 0x0000_0004 (only empty set), the level reads 0, and both card handshake outputs are low.
- R2: The command word has code [31:28], length [25:16], large-buffer select [26] and direction [0], where 1 = host to card and 0 = card to host. Writing it while idle with [26] set starts a transfer. Status then shows busy, count 0, and the new code and direction, and done clears.
- R3: A command written with bit 26 clear starts nothing and leaves the status unchanged.
- R4: A command written while busy is ignored. Code, direction and busy stay as they were.
- R5: A window write queues its four bytes in the order [31:24], [23:16], [15:8], [7:0]. The card side pops them in that order. A window read returns the oldest byte in [31:24] and fills any byte positions the FIFO cannot supply with zero.
- R6: In host-to-card mode, the cycle after the count equals the length, busy clears and done sets. A length of 0 completes at once.
- R7: In card-to-host mode, the count covers accepted card pushes. The transfer completes only once the count equals the length and the FIFO is empty.
- R8: A window read while the FIFO is empty returns zero and sets the sticky underrun flag.
- R9: The sticky mismatch flag sets on any of these: a card push or pop outside an active transfer of its direction, or after the count has reached the length; a host-to-card completion with bytes left in the FIFO; or a window write that does not fit.
- R10: Writing 1 to control bit 0 clears the FIFO, the count, busy, done, underrun, mismatch, the code and the direction.
- R11: The FIFO holds 512 bytes and shows full at that level. Window bytes that do not fit are dropped, and the level never exceeds 512.
- R12: card_rvalid_o is high only in an active host-to-card transfer with data queued and the count below the length. card_wready_o is high only in an active card-to-host transfer with room in the FIFO and the count below the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Access is a write |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register |
| card_push_i | input | 1 | Card offers a byte (card to host) |
| card_wdata_i | input | 8 | Byte offered by the card |
| card_wready_o | output | 1 | Engine accepts the offered byte |
| card_pop_i | input | 1 | Card takes a byte (host to card) |
| card_rdata_o | output | 8 | Oldest FIFO byte |
| card_rvalid_o | output | 1 | A byte may be taken |

## Verification
Several properties are checked on every cycle. The level never exceeds capacity. Each card handshake output is asserted only in its own direction while the transfer is active. Any command accepted while idle starts with a zero count, and one arriving while busy leaves code and direction unchanged. An empty-window read always raises underrun, which then stays set, and a soft reset always returns everything to idle. Other behaviour only the scenarios can show. These are the big-endian byte order through both sides, the exact completion cycle with or without leftover bytes, the zero-padding of short window reads, and the full-FIFO overflow path.

// File: rtl/xfe_pkg.sv
package xfe_pkg;
  localparam int unsigned CMD_CODE_LSB = 28;
  localparam int unsigned CMD_LEN_LSB  = 16;
  localparam int unsigned CMD_BIG_BIT  = 26;
  localparam int unsigned CMD_DIR_BIT  = 0;

  localparam int unsigned OFS_CMD  = 'h00;
  localparam int unsigned OFS_CTRL = 'h04;
  localparam int unsigned OFS_WIN  = 'h08;
  localparam int unsigned OFS_STAT = 'h0C;
  localparam int unsigned OFS_LVL  = 'h10;

  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_DONE  = 1;
  localparam int unsigned ST_EMPTY = 2;
  localparam int unsigned ST_FULL  = 3;
  localparam int unsigned ST_UNDER = 4;
  localparam int unsigned ST_MISM  = 5;
  localparam int unsigned ST_DIR   = 6;
endpackage

// File: rtl/xfe_byte_fifo.sv
module xfe_byte_fifo #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned LANES = 4,
  parameter int unsigned LVL_W = $clog2(DEPTH) + 1,
  parameter int unsigned N_W   = $clog2(LANES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic [N_W-1:0]              push_n_i,
  input  logic [LANES-1:0][7:0]       push_bytes_i,
  input  logic [N_W-1:0]              pop_n_i,
  output logic [LANES-1:0][7:0]       peek_o,
  output logic [LVL_W-1:0]            level_o,
  output logic                        empty_o,
  output logic                        full_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < LANES; i++) begin
      if (N_W'(i) < push_n_i) mem[wr_q + PTR_W'(i)] <= push_bytes_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_q + PTR_W'(push_n_i);
      rd_q  <= rd_q + PTR_W'(pop_n_i);
      lvl_q <= lvl_q + LVL_W'(push_n_i) - LVL_W'(pop_n_i);
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) peek_o[i] = mem[rd_q + PTR_W'(i)];
  end

  assign level_o = lvl_q;
  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LVL_W'(DEPTH));
endmodule

// File: rtl/xfe_host_if.sv
module xfe_host_if
  import xfe_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LVL_W  = $clog2(DEPTH) + 1,
  parameter int unsigned N_W    = $clog2(LANES + 1),
  parameter int unsigned DW     = 8 * LANES
) (
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [LVL_W-1:0]      level_i,
  input  logic [LANES-1:0][7:0] peek_i,
  input  logic [31:0]           stat_i,
  output logic                  cmd_wr_o,
  output logic                  soft_rst_o,
  output logic                  win_wr_o,
  output logic                  win_rd_o,
  output logic [N_W-1:0]        push_n_o,
  output logic [LANES-1:0][7:0] push_bytes_o,
  output logic [N_W-1:0]        pop_n_o,
  output logic                  overflow_o,
  output logic [31:0]           rdata_o
);
  logic [LVL_W-1:0] free_b;
  logic [DW-1:0]    win_word;

  assign cmd_wr_o   = req_i & we_i  & (addr_i == ADDR_W'(OFS_CMD));
  assign soft_rst_o = req_i & we_i  & (addr_i == ADDR_W'(OFS_CTRL)) & wdata_i[0];
  assign win_wr_o   = req_i & we_i  & (addr_i == ADDR_W'(OFS_WIN));
  assign win_rd_o   = req_i & ~we_i & (addr_i == ADDR_W'(OFS_WIN));

  assign free_b     = LVL_W'(DEPTH) - level_i;
  assign overflow_o = win_wr_o & (free_b < LVL_W'(LANES));

  always_comb begin
    push_n_o = '0;
    if (win_wr_o) push_n_o = (free_b >= LVL_W'(LANES)) ? N_W'(LANES) : N_W'(free_b);
    pop_n_o = '0;
    if (win_rd_o) pop_n_o = (level_i >= LVL_W'(LANES)) ? N_W'(LANES) : N_W'(level_i);
    // lane 0 is the first byte in the FIFO: most significant in the word
    for (int i = 0; i < LANES; i++) begin
      push_bytes_o[i]           = wdata_i[8*(LANES-1-i) +: 8];
      win_word[8*(LANES-1-i) +: 8] = (LVL_W'(i) < level_i) ? peek_i[i] : 8'h00;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_WIN))  rdata_o = 32'(win_word);
    if (addr_i == ADDR_W'(OFS_STAT)) rdata_o = stat_i;
    if (addr_i == ADDR_W'(OFS_LVL))  rdata_o = 32'(level_i);
  end
endmodule

// File: rtl/xfe_ctrl.sv
module xfe_ctrl
  import xfe_pkg::*;
#(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [31:0]      cmd_word_i,
  input  logic             soft_rst_i,
  input  logic             win_wr_i,
  input  logic             win_rd_i,
  input  logic             overflow_i,
  input  logic             empty_i,
  input  logic             full_i,
  input  logic             card_push_i,
  input  logic             card_pop_i,
  output logic             card_wready_o,
  output logic             card_rvalid_o,
  output logic             push_fire_o,
  output logic             pop_fire_o,
  output logic             busy_o,
  output logic             dir_o,
  output logic             done_o,
  output logic             underrun_o,
  output logic             mismatch_o,
  output logic [3:0]       code_o,
  output logic [LEN_W-1:0] cnt_o
);
  logic             busy_q, dir_q, done_q, und_q, mis_q;
  logic [3:0]       code_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             at_len, push_ok, pop_ok, start, wr_fin, rd_fin, mis_evt;

  assign at_len  = (cnt_q == len_q);
  assign push_ok = busy_q & ~dir_q & ~at_len;
  assign pop_ok  = busy_q &  dir_q & ~at_len;

  // host window access owns the FIFO port in its cycle
  assign card_wready_o = push_ok & ~full_i  & ~win_wr_i;
  assign card_rvalid_o = pop_ok  & ~empty_i & ~win_rd_i;
  assign push_fire_o   = card_push_i & card_wready_o;
  assign pop_fire_o    = card_pop_i  & card_rvalid_o;

  assign start   = cmd_wr_i & ~busy_q & cmd_word_i[CMD_BIG_BIT];
  assign wr_fin  = busy_q &  dir_q & at_len;
  assign rd_fin  = busy_q & ~dir_q & at_len & empty_i;
  assign mis_evt = (card_push_i & ~push_ok) | (card_pop_i & ~pop_ok)
                 | overflow_i | (wr_fin & ~empty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; dir_q <= 1'b0; done_q <= 1'b0; und_q <= 1'b0; mis_q <= 1'b0;
      code_q <= '0; len_q <= '0; cnt_q <= '0;
    end else if (soft_rst_i) begin
      busy_q <= 1'b0; dir_q <= 1'b0; done_q <= 1'b0; und_q <= 1'b0; mis_q <= 1'b0;
      code_q <= '0; len_q <= '0; cnt_q <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        dir_q  <= cmd_word_i[CMD_DIR_BIT];
        code_q <= cmd_word_i[CMD_CODE_LSB +: 4];
        len_q  <= cmd_word_i[CMD_LEN_LSB +: LEN_W];
        cnt_q  <= '0;
      end else begin
        if (push_fire_o | pop_fire_o) cnt_q <= cnt_q + 1'b1;
        if (wr_fin | rd_fin) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (win_rd_i & empty_i) und_q <= 1'b1;
      if (mis_evt)            mis_q <= 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign dir_o      = dir_q;
  assign done_o     = done_q;
  assign underrun_o = und_q;
  assign mismatch_o = mis_q;
  assign code_o     = code_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/xfer_fifo_engine.sv
module xfer_fifo_engine
  import xfe_pkg::*;
#(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned LEN_W  = 10,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              card_push_i,
  input  logic [7:0]        card_wdata_i,
  output logic              card_wready_o,
  input  logic              card_pop_i,
  output logic [7:0]        card_rdata_o,
  output logic              card_rvalid_o
);
  localparam int unsigned LANES = 4;
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1;
  localparam int unsigned N_W   = $clog2(LANES + 1);

  logic                  cmd_wr, soft_rst, win_wr, win_rd, overflow;
  logic [N_W-1:0]        host_push_n, host_pop_n, push_n, pop_n;
  logic [LANES-1:0][7:0] host_bytes, push_bytes, peek;
  logic [LVL_W-1:0]      level;
  logic                  empty, full, push_fire, pop_fire;
  logic                  busy, dir, done, underrun, mismatch;
  logic [3:0]            code;
  logic [LEN_W-1:0]      cnt;
  logic [31:0]           stat;

  xfe_host_if #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LANES(LANES), .LVL_W(LVL_W), .N_W(N_W)) u_host (
    .req_i, .we_i, .addr_i, .wdata_i,
    .level_i(level), .peek_i(peek), .stat_i(stat),
    .cmd_wr_o(cmd_wr), .soft_rst_o(soft_rst), .win_wr_o(win_wr), .win_rd_o(win_rd),
    .push_n_o(host_push_n), .push_bytes_o(host_bytes), .pop_n_o(host_pop_n),
    .overflow_o(overflow), .rdata_o
  );

  xfe_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .cmd_word_i(wdata_i), .soft_rst_i(soft_rst),
    .win_wr_i(win_wr), .win_rd_i(win_rd), .overflow_i(overflow),
    .empty_i(empty), .full_i(full), .card_push_i, .card_pop_i,
    .card_wready_o, .card_rvalid_o, .push_fire_o(push_fire), .pop_fire_o(pop_fire),
    .busy_o(busy), .dir_o(dir), .done_o(done), .underrun_o(underrun),
    .mismatch_o(mismatch), .code_o(code), .cnt_o(cnt)
  );

  always_comb begin
    push_n     = win_wr ? host_push_n : N_W'(push_fire);
    push_bytes = host_bytes;
    if (!win_wr) begin
      push_bytes    = '0;
      push_bytes[0] = card_wdata_i;
    end
    pop_n = win_rd ? host_pop_n : N_W'(pop_fire);
  end

  xfe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES), .LVL_W(LVL_W), .N_W(N_W)) u_fifo (
    .clk_i, .rst_ni, .clear_i(soft_rst),
    .push_n_i(push_n), .push_bytes_i(push_bytes), .pop_n_i(pop_n),
    .peek_o(peek), .level_o(level), .empty_o(empty), .full_o(full)
  );

  always_comb begin
    stat                            = '0;
    stat[ST_BUSY]                   = busy;
    stat[ST_DONE]                   = done;
    stat[ST_EMPTY]                  = empty;
    stat[ST_FULL]                   = full;
    stat[ST_UNDER]                  = underrun;
    stat[ST_MISM]                   = mismatch;
    stat[ST_DIR]                    = dir;
    stat[CMD_LEN_LSB +: LEN_W]      = cnt;
    stat[CMD_CODE_LSB +: 4]         = code;
  end

  assign card_rdata_o = peek[0];
endmodule

// File: rtl/xfe_checker.sv
module xfe_checker
  import xfe_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned LVL_W = $clog2(DEPTH) + 1,
  parameter int unsigned LEN_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_wr_i,
  input logic [31:0]      cmd_word_i,
  input logic             soft_rst_i,
  input logic             win_rd_i,
  input logic             busy_i,
  input logic             dir_i,
  input logic             done_i,
  input logic             underrun_i,
  input logic             mismatch_i,
  input logic [3:0]       code_i,
  input logic [LEN_W-1:0] cnt_i,
  input logic [LVL_W-1:0] level_i,
  input logic             empty_i,
  input logic             card_rvalid_i,
  input logic             card_wready_i
);
  p_level_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LVL_W'(DEPTH));

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && cmd_wr_i && cmd_word_i[CMD_BIG_BIT] && !soft_rst_i)
    |=> (busy_i && cnt_i == '0 && !done_i && code_i == $past(cmd_word_i[CMD_CODE_LSB +: 4])));

  p_no_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && cmd_wr_i && !cmd_word_i[CMD_BIG_BIT] && !soft_rst_i) |=> !busy_i);

  p_busy_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cmd_wr_i && !soft_rst_i) |=> ($stable(code_i) && $stable(dir_i)));

  p_underrun_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd_i && empty_i && !soft_rst_i) |=> underrun_i);

  p_underrun_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_i && !soft_rst_i) |=> underrun_i);

  p_soft_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (level_i == '0 && !busy_i && !done_i && !underrun_i && !mismatch_i && cnt_i == '0));

  p_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rvalid_i |-> (busy_i && dir_i && !empty_i));

  p_wready_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_wready_i |-> (busy_i && !dir_i && level_i < LVL_W'(DEPTH)));
endmodule

bind xfer_fifo_engine xfe_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W), .LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr), .cmd_word_i(wdata_i),
  .soft_rst_i(soft_rst), .win_rd_i(win_rd), .busy_i(busy), .dir_i(dir), .done_i(done),
  .underrun_i(underrun), .mismatch_i(mismatch), .code_i(code), .cnt_i(cnt),
  .level_i(level), .empty_i(empty), .card_rvalid_i(card_rvalid_o), .card_wready_i(card_wready_o)
);

// File: tb/xfer_fifo_engine_tb.sv
`timescale 1ns/1ps
module xfer_fifo_engine_tb;
  localparam logic [4:0] A_CMD = 5'h00, A_CTRL = 5'h04, A_WIN = 5'h08, A_STAT = 5'h0C, A_LVL = 5'h10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        card_push_i = 1'b0, card_pop_i = 1'b0;
  logic [7:0]  card_wdata_i = '0, card_rdata_o;
  logic        card_wready_o, card_rvalid_o;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  logic [7:0] exp_b;
  logic [31:0] rd;

  always #2 clk_i = ~clk_i;

  xfer_fifo_engine u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  // driver: window write, scoreboard learns the bytes in big-endian order
  task automatic host_push_word(input logic [31:0] w);
    bus_write(A_WIN, w);
    for (int i = 3; i >= 0; i--) exp_q.push_back(w[8*i +: 8]);
  endtask

  task automatic card_pop_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      card_pop_i = 1'b1;
      #1;
      while (!card_rvalid_o) begin @(negedge clk_i); #1; end
    end
    @(negedge clk_i);
    card_pop_i = 1'b0;
  endtask

  task automatic card_push_bytes(input logic [7:0] first, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      card_push_i = 1'b1; card_wdata_i = first + 8'(i);
      #1;
      while (!card_wready_o) begin @(negedge clk_i); #1; end
    end
    @(negedge clk_i);
    card_push_i = 1'b0;
  endtask

  task automatic soft_reset();
    bus_write(A_CTRL, 32'h1);
    exp_q.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: compare each byte the card takes against the scoreboard (R5)
  always @(posedge clk_i) begin
    if (rst_ni && card_pop_i && card_rvalid_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R5: actual %02h expected <none>", card_rdata_o);
      end else begin
        exp_b = exp_q.pop_front();
        if (card_rdata_o !== exp_b) begin
          n_err++;
          $display("FAIL R5: actual %02h expected %02h", card_rdata_o, exp_b);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    bus_read(A_STAT, rd); check("R1 status", rd, 32'h0000_0004);
    bus_read(A_LVL, rd);  check("R1 level", rd, 32'd0);
    check("R1 handshakes", {30'd0, card_rvalid_o, card_wready_o}, 32'd0);

    // R2/R5/R6 host-to-card, len 8, code 5
    bus_write(A_CMD, 32'h5408_0001);
    bus_read(A_STAT, rd); check("R2 start", rd, 32'h5000_0045);
    host_push_word(32'h1122_3344);
    host_push_word(32'hA5B6_C7D8);
    bus_read(A_LVL, rd); check("R5 level", rd, 32'd8);
    card_pop_bytes(8);
    idle(2);
    bus_read(A_STAT, rd); check("R6 done", rd, 32'h5008_0046);

    // R4 command while busy
    bus_write(A_CMD, 32'h3404_0001);
    bus_read(A_STAT, rd); check("R2 restart", rd, 32'h3000_0045);
    bus_write(A_CMD, 32'h9402_0000);
    bus_read(A_STAT, rd); check("R4 ignored", rd, 32'h3000_0045);
    host_push_word(32'hDEAD_BEEF);
    card_pop_bytes(4);
    idle(2);
    bus_read(A_STAT, rd); check("R4 first completes", rd, 32'h3004_0046);

    // R3 select bit clear
    bus_write(A_CMD, 32'h7004_0001);
    bus_read(A_STAT, rd); check("R3 no start", rd, 32'h3004_0046);

    // R7/R12 card-to-host, len 6, code 2
    bus_write(A_CMD, 32'h2406_0000);
    bus_read(A_STAT, rd); check("R2 read start", rd, 32'h2000_0005);
    card_push_bytes(8'h01, 6);
    #1 check("R12 wready at length", {31'd0, card_wready_o}, 32'd0);
    bus_read(A_STAT, rd); check("R7 busy until drained", rd, 32'h2006_0001);
    bus_read(A_WIN, rd); check("R5 window read", rd, 32'h0102_0304);
    bus_read(A_WIN, rd); check("R5 short read pad", rd, 32'h0506_0000);
    idle(2);
    bus_read(A_STAT, rd); check("R7 done", rd, 32'h2006_0006);

    // R8 underrun
    bus_read(A_WIN, rd); check("R8 empty read data", rd, 32'd0);
    bus_read(A_STAT, rd); check("R8 underrun", rd, 32'h2006_0016);

    // R10 soft reset
    soft_reset();
    bus_read(A_STAT, rd); check("R10 cleared", rd, 32'h0000_0004);

    // R9 leftover bytes at completion
    bus_write(A_CMD, 32'h1404_0001);
    host_push_word(32'hCAFE_F00D);
    host_push_word(32'h0BAD_1DEA);
    card_pop_bytes(4);
    idle(2);
    bus_read(A_STAT, rd); check("R9 leftover", rd, 32'h1004_0062);
    bus_read(A_LVL, rd);  check("R9 leftover level", rd, 32'd4);
    soft_reset();
    bus_read(A_LVL, rd);  check("R10 level cleared", rd, 32'd0);

    // R9 stray pop while idle
    @(negedge clk_i); card_pop_i = 1'b1;
    @(negedge clk_i); card_pop_i = 1'b0;
    bus_read(A_STAT, rd); check("R9 stray pop", rd, 32'h0000_0024);
    soft_reset();

    // R11 capacity and overflow
    for (int i = 0; i < 128; i++) bus_write(A_WIN, 32'(i));
    bus_read(A_LVL, rd);  check("R11 full level", rd, 32'd512);
    bus_read(A_STAT, rd); check("R11 full flag", rd, 32'h0000_0008);
    bus_write(A_WIN, 32'hFFFF_FFFF);
    bus_read(A_LVL, rd);  check("R11 no growth", rd, 32'd512);
    bus_read(A_STAT, rd); check("R11 overflow mismatch", rd, 32'h0000_0028);
    soft_reset();

    // R6 zero length
    bus_write(A_CMD, 32'h4400_0001);
    idle(2);
    bus_read(A_STAT, rd); check("R6 zero length", rd, 32'h4000_0046);
    soft_reset();

    // R12 no card valid while idle
    bus_write(A_WIN, 32'h1234_5678);
    #1 check("R12 idle rvalid", {31'd0, card_rvalid_o}, 32'd0);
    bus_read(A_LVL, rd); check("R12 data held", rd, 32'd4);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule